// File: doc/BRIEF.md
# Serial-Port Data FIFO with Level Compares and Interrupt Status

This block is the data buffer that sits between a serial shift engine and the register side of a serial peripheral controller. The same RTL serves on the send side and on the receive side; a parameter picks which one. The storage holds 256 bytes. Each entry is one byte, one halfword or one word wide, so the FIFO holds 256, 128 or 64 entries. A command input empties the FIFO and starts or stops it. While it is stopped, pushes and pops have no effect.

The block reports its fill level in bytes, together with full and empty flags. It also produces four compare outputs: one against an 8-bit byte threshold, and three against 6-bit word-granular levels (low, high and stop) taken from one packed configuration word. Full, empty, threshold, overflow and underflow conditions, plus three externally supplied transfer events, are collected in an 11-bit sticky status register. Writing a one to a status bit clears it. An enable mask selects which status bits drive the single interrupt output.

Top module: `spi_lvl_fifo`

## Requirements
- R1: After reset the FIFO is stopped and empty. `fill_stat` reads 10'h200, `int_stat` reads 0 and `irq` is low.
- R2: A write on `op_wr` with `op_val` bit 0 set empties the FIFO. `op_val` bit 1 gives the new run state: 1 runs, 0 stops. Stopping does not discard the contents. While the FIFO is stopped, push and pop change nothing and set neither the overflow nor the underflow bit.
- R3: Data leaves in the order it entered. A pushed value is masked to the entry width given by `width_sel`: 0 keeps bits 7:0, 1 keeps bits 15:0, 2 or 3 keep all 32 bits. `pop_data` shows the popped entry after the clock edge that accepts the pop.
- R4: The level in bytes equals the entry count times the entry size, and the capacity is 256 bytes. `fill_stat` carries level bits 7:0 in bits 7:0, the full flag in bit 8 and the empty flag in bit 9. A full byte-mode FIFO therefore reads 10'h100.
- R5: A push into a full FIFO is dropped and sets status bit 2. A pop from an empty FIFO is dropped and sets status bit 3. Both bits are visible after the same edge. When push and pop arrive together on a full FIFO, the pop is taken and the push is dropped. When they arrive together on an empty FIFO, the push is taken and the pop is dropped.
- R6: `thr_hit` is high when the byte level is at or above `thresh` on a receive instance (`IS_TX`=0), and at or below `thresh` on a send instance (`IS_TX`=1). It sets status bit 8 on a receive instance and status bit 9 on a send instance.
- R7: `lvl_chk` holds the stop level in bits 5:0, the low level in bits 15:10 and the high level in bits 25:20, each counted in 4-byte words. With W = floor(level/4): `low_hit` = W <= low, `high_hit` = W >= high, and `stop_hit` = W >= stop.
- R8: Status bits are sticky. Bit 6 (full) and bit 7 (empty) set on the edge after a cycle in which the condition holds. `evt_in` bits 0, 1 and 2 set status bits 0, 1 and 10. Bits 4 and 5 always read 0. A bit clears only when `clr_wr` is high with a one in that bit of `clr_data`.
- R9: When a set condition and a clear land on the same status bit in the same cycle, the bit stays set.
- R10: `irq` is the OR of `int_stat & int_en` and updates on the same edge as `int_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_wr | input | 1 | Operation command strobe |
| op_val | input | 2 | Bit 0 empties the FIFO; bit 1 is the new run state |
| width_sel | input | 2 | Entry width: 0 byte, 1 halfword, 2/3 word |
| thresh | input | 8 | Byte threshold |
| lvl_chk | input | 32 | Packed stop/low/high word levels |
| push | input | 1 | Push request |
| push_data | input | 32 | Push data |
| pop | input | 1 | Pop request |
| pop_data | output | 32 | Last popped entry |
| fill_stat | output | 10 | Empty, full and level[7:0] |
| thr_hit | output | 1 | Threshold compare result |
| low_hit | output | 1 | Low level compare |
| high_hit | output | 1 | High level compare |
| stop_hit | output | 1 | Stop level compare |
| evt_in | input | 3 | Receive-done, send-done and frame-end event pulses |
| int_en | input | 11 | Interrupt enable mask |
| clr_wr | input | 1 | Status clear strobe |
| clr_data | input | 11 | Write-one-to-clear mask |
| int_stat | output | 11 | Sticky interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the FIFO until it is full in byte mode and then pushes once more. A design that wrapped its pointer instead of refusing the push would overwrite the oldest byte, and the following pops would return the wrong data and no overflow bit. It checks the threshold compare at exactly the threshold level on both a receive and a send instance. An off-by-one or a swapped direction shows up as a wrong `thr_hit` there. It places a set event and a clear on the same status bit in one cycle. A design that let the clear win would lose the event. It also pushes and pops while the FIFO is stopped. A design that ignored the run state would change the level or raise overflow or underflow.

// File: rtl/spi_lvl_fifo_pkg.sv
package spi_lvl_fifo_pkg;
  localparam int DATA_W = 32;
  localparam int STAT_W = 11;
  localparam int LVL_W  = 6;

  // status bit positions
  localparam int B_RXDONE = 0;
  localparam int B_TXDONE = 1;
  localparam int B_OVF    = 2;
  localparam int B_UNF    = 3;
  localparam int B_FULL   = 6;
  localparam int B_EMPTY  = 7;
  localparam int B_RXTHR  = 8;
  localparam int B_TXTHR  = 9;
  localparam int B_FRAME  = 10;

  // packed level-check field positions
  localparam int STOP_LSB = 0;
  localparam int LOW_LSB  = 10;
  localparam int HIGH_LSB = 20;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_WORD = 2'd2,
    W_WALT = 2'd3
  } width_e;

  function automatic logic [1:0] width_log(input logic [1:0] sel);
    case (width_e'(sel))
      W_BYTE:  return 2'd0;
      W_HALF:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sel);
    case (width_e'(sel))
      W_BYTE:  return DATA_W'(32'h0000_00FF);
      W_HALF:  return DATA_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/spi_lvl_fifo_store.sv
module spi_lvl_fifo_store #(
  parameter int DEPTH_BYTES = 256,
  parameter int DW          = 32,
  localparam int AW         = $clog2(DEPTH_BYTES),
  localparam int CW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          run,
  input  logic [1:0]    wlog,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_drop
);
  logic [CW-1:0] cap;
  logic [CW-1:0] last;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;
  logic [DW-1:0] mem [DEPTH_BYTES];

  // entry capacity shrinks with entry size
  assign cap   = CW'(DEPTH_BYTES) >> wlog;
  assign last  = cap - 1'b1;
  assign full  = (count == cap);
  assign empty = (count == '0);

  assign do_push   = run && push && !full  && !flush;
  assign do_pop    = run && pop  && !empty && !flush;
  assign push_drop = run && push && full   && !flush;
  assign pop_drop  = run && pop  && empty  && !flush;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input logic [CW-1:0] lim);
    return ({1'b0, p} == lim) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= adv(wr_ptr, last);
      if (do_pop)  rd_ptr <= adv(rd_ptr, last);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
    if (do_pop)  rdata <= mem[rd_ptr];
  end

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !flush) |=> $stable(count));
  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push_drop && !pop) |=> $stable(count));
endmodule

// File: rtl/spi_lvl_fifo_cmp.sv
module spi_lvl_fifo_cmp #(
  parameter int CW    = 9,
  parameter bit IS_TX = 1'b0
) (
  input  logic [CW-1:0] level,
  input  logic [7:0]    thresh,
  input  logic [5:0]    stop_lvl,
  input  logic [5:0]    low_lvl,
  input  logic [5:0]    high_lvl,
  output logic          thr_hit,
  output logic          low_hit,
  output logic          high_hit,
  output logic          stop_hit
);
  logic [CW-1:0] words;

  assign words    = level >> 2;
  assign low_hit  = (words <= CW'(low_lvl));
  assign high_hit = (words >= CW'(high_lvl));
  assign stop_hit = (words >= CW'(stop_lvl));

  generate
    if (IS_TX) begin : g_send
      assign thr_hit = (level <= CW'(thresh));
    end else begin : g_recv
      assign thr_hit = (level >= CW'(thresh));
    end
  endgenerate
endmodule

// File: rtl/spi_lvl_fifo_irq.sv
module spi_lvl_fifo_irq #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  input  logic [W-1:0] int_en,
  output logic [W-1:0] stat,
  output logic         irq
);
  logic [W-1:0] clr_mask;
  logic [W-1:0] stat_d;

  assign clr_mask = clr_wr ? clr_data : '0;
  // set takes priority over clear
  assign stat_d   = (stat & ~clr_mask) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_d;
      irq  <= |(stat_d & int_en);
    end
  end

  // R9
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((stat & $past(set_vec)) == $past(set_vec)));
  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((stat & $past(clr_data & ~set_vec)) == '0));
  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat & $past(int_en)));
endmodule

// File: rtl/spi_lvl_fifo.sv
module spi_lvl_fifo
  import spi_lvl_fifo_pkg::*;
#(
  parameter int DEPTH_BYTES = 256,
  parameter bit IS_TX       = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_wr,
  input  logic [1:0]        op_val,
  input  logic [1:0]        width_sel,
  input  logic [7:0]        thresh,
  input  logic [31:0]       lvl_chk,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [9:0]        fill_stat,
  output logic              thr_hit,
  output logic              low_hit,
  output logic              high_hit,
  output logic              stop_hit,
  input  logic [2:0]        evt_in,
  input  logic [STAT_W-1:0] int_en,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_data,
  output logic [STAT_W-1:0] int_stat,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH_BYTES) + 1;

  logic              run;
  logic              flush;
  logic [1:0]        wlog;
  logic [CW-1:0]     count;
  logic [CW-1:0]     level_bytes;
  logic              full;
  logic              empty;
  logic              push_drop;
  logic              pop_drop;
  logic [STAT_W-1:0] set_vec;
  logic              chk_unused;

  assign flush = op_wr && op_val[0];
  assign wlog  = width_log(width_sel);

  always_ff @(posedge clk) begin
    if (rst)        run <= 1'b0;
    else if (op_wr) run <= op_val[1];
  end

  spi_lvl_fifo_store #(
    .DEPTH_BYTES(DEPTH_BYTES),
    .DW         (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .run      (run),
    .wlog     (wlog),
    .push     (push),
    .wdata    (push_data & width_mask(width_sel)),
    .pop      (pop),
    .rdata    (pop_data),
    .count    (count),
    .full     (full),
    .empty    (empty),
    .push_drop(push_drop),
    .pop_drop (pop_drop)
  );

  assign level_bytes = count << wlog;
  assign fill_stat   = {empty, full, 8'(level_bytes)};

  spi_lvl_fifo_cmp #(
    .CW   (CW),
    .IS_TX(IS_TX)
  ) u_cmp (
    .level   (level_bytes),
    .thresh  (thresh),
    .stop_lvl(lvl_chk[STOP_LSB +: LVL_W]),
    .low_lvl (lvl_chk[LOW_LSB  +: LVL_W]),
    .high_lvl(lvl_chk[HIGH_LSB +: LVL_W]),
    .thr_hit (thr_hit),
    .low_hit (low_hit),
    .high_hit(high_hit),
    .stop_hit(stop_hit)
  );

  assign chk_unused = ^{lvl_chk[31:26], lvl_chk[19:16], lvl_chk[9:6]};

  always_comb begin
    set_vec           = '0;
    set_vec[B_RXDONE] = evt_in[0];
    set_vec[B_TXDONE] = evt_in[1];
    set_vec[B_FRAME]  = evt_in[2];
    set_vec[B_OVF]    = push_drop;
    set_vec[B_UNF]    = pop_drop;
    set_vec[B_FULL]   = full;
    set_vec[B_EMPTY]  = empty;
    if (IS_TX) set_vec[B_TXTHR] = thr_hit;
    else       set_vec[B_RXTHR] = thr_hit;
  end

  spi_lvl_fifo_irq #(
    .W(STAT_W)
  ) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_wr  (clr_wr),
    .clr_data(clr_data),
    .int_en  (int_en),
    .stat    (int_stat),
    .irq     (irq)
  );

  // R4
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fill_stat[8] && fill_stat[9]));
endmodule

// File: tb/spi_lvl_fifo_tb.sv
module spi_lvl_fifo_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_wr = 1'b0;
  logic [1:0]  op_val = '0;
  logic [1:0]  width_sel = '0;
  logic [7:0]  thresh = '0;
  logic [31:0] lvl_chk = '0;
  logic        push = 1'b0;
  logic [31:0] push_data = '0;
  logic        pop = 1'b0;
  logic [2:0]  evt_in = '0;
  logic [10:0] int_en = '0;
  logic        clr_wr = 1'b0;
  logic [10:0] clr_data = '0;

  logic [31:0] pop_data, pop_data_t;
  logic [9:0]  fill_stat, fill_stat_t;
  logic        thr_hit, low_hit, high_hit, stop_hit;
  logic        thr_hit_t, low_hit_t, high_hit_t, stop_hit_t;
  logic [10:0] int_stat, int_stat_t;
  logic        irq, irq_t;

  always #(CLK_P/2) clk = ~clk;

  spi_lvl_fifo #(.IS_TX(1'b0)) u_dut (
    .clk(clk), .rst(rst), .op_wr(op_wr), .op_val(op_val), .width_sel(width_sel),
    .thresh(thresh), .lvl_chk(lvl_chk), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .fill_stat(fill_stat), .thr_hit(thr_hit), .low_hit(low_hit),
    .high_hit(high_hit), .stop_hit(stop_hit), .evt_in(evt_in), .int_en(int_en),
    .clr_wr(clr_wr), .clr_data(clr_data), .int_stat(int_stat), .irq(irq));

  spi_lvl_fifo #(.IS_TX(1'b1)) u_dut_tx (
    .clk(clk), .rst(rst), .op_wr(op_wr), .op_val(op_val), .width_sel(width_sel),
    .thresh(thresh), .lvl_chk(lvl_chk), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data_t), .fill_stat(fill_stat_t), .thr_hit(thr_hit_t), .low_hit(low_hit_t),
    .high_hit(high_hit_t), .stop_hit(stop_hit_t), .evt_in(evt_in), .int_en(int_en),
    .clr_wr(clr_wr), .clr_data(clr_data), .int_stat(int_stat_t), .irq(irq_t));

  int total = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  logic [31:0] mq[$];
  int  cap = 256;
  int  bpe = 1;
  logic [31:0] mask = 32'hFF;
  bit  running = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_fill();
    int lv = mq.size() * bpe;
    return {mq.size() == 0, mq.size() == cap, 8'(lv)};
  endfunction

  task automatic set_width(input logic [1:0] w);
    width_sel = w;
    bpe  = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    cap  = 256 / bpe;
    mask = (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endtask

  task automatic op(input logic [1:0] v);
    op_wr = 1'b1; op_val = v;
    @(posedge clk); @(negedge clk);
    op_wr = 1'b0; op_val = '0;
    if (v[0]) mq.delete();
    running = v[1];
  endtask

  task automatic step(input logic p, input logic q, input logic [31:0] d, input bit flags);
    int sz;
    int lv;
    int wds;
    bit popped;
    logic [31:0] ev;
    push = p; pop = q; push_data = d;
    @(posedge clk); @(negedge clk);
    push = 1'b0; pop = 1'b0;
    popped = 0;
    ev = '0;
    if (running) begin
      sz = mq.size();
      if (q && sz != 0) begin ev = mq.pop_front(); popped = 1; end
      if (p && sz != cap) mq.push_back(d & mask);
    end
    if (popped) chk("R3 pop order/mask", pop_data, ev);
    chk("R4 fill_stat", 32'(fill_stat), 32'(exp_fill()));
    if (flags) begin
      lv  = mq.size() * bpe;
      wds = lv / 4;
      chk("R6 rx threshold", 32'(thr_hit),   32'(lv >= int'(thresh)));
      chk("R6 tx threshold", 32'(thr_hit_t), 32'(lv <= int'(thresh)));
      chk("R7 low_hit",  32'(low_hit),  32'(wds <= int'(lvl_chk[15:10])));
      chk("R7 high_hit", 32'(high_hit), 32'(wds >= int'(lvl_chk[25:20])));
      chk("R7 stop_hit", 32'(stop_hit), 32'(wds >= int'(lvl_chk[5:0])));
    end
  endtask

  task automatic pulse(input logic [2:0] ev, input logic cw, input logic [10:0] cd);
    evt_in = ev; clr_wr = cw; clr_data = cd;
    @(posedge clk); @(negedge clk);
    evt_in = '0; clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [9:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 fill after reset", 32'(fill_stat), 32'h200);
    chk("R1 int_stat after reset", 32'(int_stat), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    // R1/R2 stopped after reset: push ignored
    step(1'b1, 1'b0, 32'h55, 1'b0);
    chk("R2 push while stopped", 32'(fill_stat), 32'h200);
    chk("R2 no overflow while stopped", 32'(int_stat[2]), 32'h0);

    // random phase for each entry width
    for (int w = 0; w < 3; w++) begin
      set_width(2'(w));
      thresh  = 8'($urandom % 256);
      lvl_chk = {6'd0, 6'($urandom % 64), 4'd0, 6'($urandom % 64), 4'd0, 6'($urandom % 64)};
      op(2'b11);
      for (int c = 0; c < 800; c++) begin
        int bias = (c < 500) ? 75 : 20;
        step(($urandom % 100) < bias, ($urandom % 100) < (100 - bias), $urandom, 1'b1);
      end
    end

    // R2 stop keeps contents, ignores push and pop
    set_width(2'd0);
    op(2'b11);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 32'(i), 1'b0);
    op(2'b00);
    pulse(3'b000, 1'b1, 11'h7FF);
    step(1'b1, 1'b0, 32'h77, 1'b0);
    step(1'b0, 1'b1, 32'h0, 1'b0);
    chk("R2 level kept while stopped", 32'(fill_stat), 32'h004);
    chk("R2 no ovf/unf while stopped", 32'(int_stat & 11'h00C), 32'h0);
    op(2'b01);
    chk("R2 flush empties", 32'(fill_stat), 32'h200);
    op(2'b10);

    // R8 empty bit sticky, cleared after data arrives
    idle(2);
    chk("R8 empty bit set", 32'(int_stat[7]), 32'h1);
    chk("R8 spare bits zero", 32'(int_stat[5:4]), 32'h0);
    step(1'b1, 1'b0, 32'h9, 1'b0);
    pulse(3'b000, 1'b1, 11'h080);
    chk("R8 empty bit cleared by w1c", 32'(int_stat[7]), 32'h0);
    step(1'b0, 1'b1, 32'h0, 1'b0);

    // R4/R5 fill to capacity in byte mode, overflow, then drain and underflow
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0, 32'(i + 16), 1'b0);
    chk("R4 full byte mode", 32'(fill_stat), 32'h100);
    pulse(3'b000, 1'b1, 11'h7FF);
    step(1'b1, 1'b0, 32'hAA, 1'b0);
    chk("R5 overflow bit", 32'(int_stat[2]), 32'h1);
    chk("R5 full after dropped push", 32'(fill_stat), 32'h100);
    idle(1);
    chk("R8 full bit set", 32'(int_stat[6]), 32'h1);
    pulse(3'b000, 1'b1, 11'h044);
    chk("R9 full bit kept under clear", 32'(int_stat[6]), 32'h1);
    chk("R8 overflow bit cleared", 32'(int_stat[2]), 32'h0);
    step(1'b1, 1'b1, 32'hBB, 1'b0);
    chk("R5 push dropped with pop on full", 32'(fill_stat), 32'h0FF);
    for (int i = 1; i < 256; i++) step(1'b0, 1'b1, 32'h0, 1'b0);
    chk("R5 drained", 32'(fill_stat), 32'h200);
    step(1'b0, 1'b1, 32'h0, 1'b0);
    chk("R5 underflow bit", 32'(int_stat[3]), 32'h1);
    step(1'b1, 1'b1, 32'h3C, 1'b0);
    chk("R5 push taken with pop on empty", 32'(fill_stat), 32'h001);
    step(1'b0, 1'b1, 32'h0, 1'b0);

    // R9 event and clear in same cycle
    pulse(3'b000, 1'b1, 11'h7FF);
    pulse(3'b001, 1'b1, 11'h001);
    chk("R9 event beats clear", 32'(int_stat[0]), 32'h1);
    pulse(3'b000, 1'b1, 11'h001);
    chk("R8 bit0 cleared", 32'(int_stat[0]), 32'h0);

    // R8 frame-end event sticky
    pulse(3'b100, 1'b0, 11'h0);
    idle(3);
    chk("R8 frame end sticky", 32'(int_stat[10]), 32'h1);

    // R10 interrupt masking
    int_en = 11'h001;
    idle(1);
    chk("R10 irq low when masked bits only", 32'(irq), 32'h0);
    pulse(3'b010, 1'b0, 11'h0);
    chk("R10 irq ignores disabled bit1", 32'(irq), 32'h0);
    pulse(3'b001, 1'b0, 11'h0);
    chk("R10 irq on enabled bit0", 32'(irq), 32'h1);
    pulse(3'b000, 1'b1, 11'h001);
    chk("R10 irq drops with clear", 32'(irq), 32'h0);
    int_en = '0;

    // R3 halfword masking
    set_width(2'd1);
    op(2'b11);
    step(1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0);
    chk("R4 halfword level", 32'(fill_stat), 32'h002);
    step(1'b0, 1'b1, 32'h0, 1'b0);
    chk("R3 halfword mask", pop_data, 32'h0000_BEEF);

    // R6 threshold boundary on both sides
    set_width(2'd0);
    thresh = 8'd5;
    op(2'b11);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 32'(i), 1'b0);
    chk("R6 rx at threshold", 32'(thr_hit), 32'h1);
    chk("R6 tx at threshold", 32'(thr_hit_t), 32'h1);
    step(1'b1, 1'b0, 32'h5, 1'b0);
    chk("R6 rx above threshold", 32'(thr_hit), 32'h1);
    chk("R6 tx above threshold", 32'(thr_hit_t), 32'h0);
    pulse(3'b000, 1'b1, 11'h7FF);
    idle(1);
    chk("R6 rx status bit8", 32'(int_stat[8]), 32'h1);
    chk("R6 tx status bit9 clear", 32'(int_stat_t[9]), 32'h0);

    held = fill_stat;
    chk("R4 final level", 32'(held), 32'h006);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule